// File: doc/BRIEF.md
# Packed Decimal Byte Arithmetic Unit

This unit carries out two-digit packed decimal arithmetic on one byte per transaction. It offers three operations: decimal add with an incoming extend bit, decimal subtract with an incoming extend bit, and decimal negate with an incoming extend bit. The extend bit is the carry or borrow from the previous, less significant byte. A caller walks a multi-byte decimal number one byte at a time. It feeds the extend and zero flags returned for one byte into the request for the next byte. At the end of the chain, the zero flag is set only if every byte came out zero.

A request carries the operation code, a destination byte, a source byte, the incoming extend bit and the incoming zero flag. It is accepted on a valid/ready handshake. The answer appears one cycle after acceptance. It holds the corrected byte and five flags: carry, extend, zero, negative and overflow. The output also uses valid/ready. The unit holds at most one result. `in_ready` is high when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and flags stay frozen and no new request is accepted.

Digits above 9 are not rejected. They pass through the same binary correction steps as legal digits, so every input byte yields a fixed, repeatable answer.

Top module: `bcd_byte_alu`

## Requirements
- R1: Add (`in_op` = 2'b00): the low sum is d[3:0]+s[3:0]+x. The uncorrected sum is (d&F0)+(s&F0)+low sum. Add 6 when the low sum exceeds 9. Carry is set when that value masked with 0x3F0 exceeds 0x90, and a set carry adds a further 0x60. The result is bits 7:0.
- R2: Add overflow is set exactly when bit 7 of the uncorrected sum is 0 and bit 7 of the result is 1.
- R3: Subtract (`in_op` = 2'b01): the low difference d[3:0]-s[3:0]-x is formed. If it borrows out of the nibble, 6 is subtracted from (d&F0)-(s&F0)+low difference. A further 0x60 is subtracted when the plain byte difference d-s-x is negative.
- R4: Subtract carry is set when d-s-x minus the low correction (6 or 0) is negative.
- R5: Subtract overflow is set exactly when bit 7 of the uncorrected difference is 1 and bit 7 of the result is 0.
- R6: Negate (`in_op[1]` = 1): the destination byte is ignored. The value 0-s-x is formed, with 6 subtracted when the low part is nonzero. Carry is set when bits 8:4 of that value exceed 0x09, and a set carry subtracts 0x60. Overflow is 0.
- R7: The extend output always equals the carry output.
- R8: The negative output equals bit 7 of the result byte.
- R9: The zero output is 1 only when `in_z` was 1 and the result byte is 0x00.
- R10: Both `in_op` codes 2'b10 and 2'b11 select negate.
- R11: A request accepted at a clock edge appears on the outputs after that edge with `out_valid` high. `in_ready` = !out_valid || out_ready. A stalled result stays unchanged, and `out_valid` falls when a result drains with no new request.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken |
| in_op | input | 2 | 00 add, 01 subtract, 1x negate |
| in_dst | input | 8 | Destination (minuend or addend) byte |
| in_src | input | 8 | Source byte |
| in_x | input | 1 | Incoming extend bit |
| in_z | input | 1 | Incoming zero flag of the chain |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_res | output | 8 | Corrected decimal byte |
| out_c | output | 1 | Carry / borrow |
| out_x | output | 1 | Extend (copy of carry) |
| out_z | output | 1 | Chained zero flag |
| out_n | output | 1 | Negative (bit 7) |
| out_v | output | 1 | Overflow across correction |

## Verification
The assertions check, on every cycle, the relations between outputs that hold for any operand: extend equals carry, negative follows bit 7, a set zero flag implies a zero byte, and a stalled result is frozen while the unit refuses input. The bench is what shows the correction arithmetic itself. That covers the nibble adjust, the 0x60 adjust, the carry thresholds, overflow across the correction, and the handling of non-decimal digits. It does this through hand-worked vectors for each operation, including chained zero propagation and the negate alias code.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int OP_W   = 2;

  typedef struct packed {
    logic [BYTE_W-1:0] res;
    logic              c;
    logic              v;
  } bcd_out_t;
endpackage

// File: rtl/bcd_add_path.sv
module bcd_add_path
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] d,
  input  logic [BYTE_W-1:0] s,
  input  logic              x,
  output bcd_out_t          o
);
  logic [NIB_W:0]    lo_sum;
  logic [9:0]        raw_sum;
  logic [9:0]        adj_sum;
  logic              cy;
  logic [BYTE_W-1:0] fin;

  always_comb begin
    lo_sum  = {1'b0, d[NIB_W-1:0]} + {1'b0, s[NIB_W-1:0]} + {{NIB_W{1'b0}}, x};
    raw_sum = {2'b00, d[BYTE_W-1:NIB_W], 4'h0} + {2'b00, s[BYTE_W-1:NIB_W], 4'h0}
            + {5'b0, lo_sum};
    adj_sum = raw_sum + ((lo_sum > 5'd9) ? 10'd6 : 10'd0);
    cy      = (adj_sum & 10'h3F0) > 10'h090;
    fin     = adj_sum[BYTE_W-1:0] + (cy ? 8'h60 : 8'h00);
    o.res   = fin;
    o.c     = cy;
    o.v     = ~raw_sum[7] & fin[7];
  end
endmodule

// File: rtl/bcd_sub_path.sv
module bcd_sub_path
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] d,
  input  logic [BYTE_W-1:0] s,
  input  logic              x,
  output bcd_out_t          o
);
  logic [NIB_W:0]    lo_diff;
  logic              nib_borrow;
  logic              byte_borrow;
  logic [BYTE_W-1:0] raw_diff;
  logic [BYTE_W-1:0] fin;
  logic [9:0]        sub_total;

  always_comb begin
    lo_diff     = {1'b0, d[NIB_W-1:0]} - {1'b0, s[NIB_W-1:0]} - {{NIB_W{1'b0}}, x};
    nib_borrow  = lo_diff[NIB_W];
    raw_diff    = {d[BYTE_W-1:NIB_W], 4'h0} - {s[BYTE_W-1:NIB_W], 4'h0}
                + {{3{lo_diff[NIB_W]}}, lo_diff};
    byte_borrow = {1'b0, d} < ({1'b0, s} + {8'b0, x});
    fin         = raw_diff - (nib_borrow ? 8'h06 : 8'h00) - (byte_borrow ? 8'h60 : 8'h00);
    sub_total   = {2'b00, s} + {9'b0, x} + (nib_borrow ? 10'd6 : 10'd0);
    o.res       = fin;
    o.c         = {2'b00, d} < sub_total;
    o.v         = raw_diff[7] & ~fin[7];
  end
endmodule

// File: rtl/bcd_neg_path.sv
module bcd_neg_path
  import bcd_pkg::*;
(
  input  logic [BYTE_W-1:0] s,
  input  logic              x,
  output bcd_out_t          o
);
  logic [NIB_W:0]    lo_mag;
  logic [8:0]        neg_val;
  logic              cy;

  always_comb begin
    lo_mag  = {1'b0, s[NIB_W-1:0]} + {{NIB_W{1'b0}}, x};
    neg_val = 9'd0 - {1'b0, s[BYTE_W-1:NIB_W], 4'h0} - {4'b0, lo_mag}
            - ((lo_mag != 5'd0) ? 9'd6 : 9'd0);
    cy      = neg_val[8:4] > 5'h09;
    o.res   = neg_val[BYTE_W-1:0] - (cy ? 8'h60 : 8'h00);
    o.c     = cy;
    o.v     = 1'b0;
  end
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
  import bcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [BYTE_W-1:0] in_dst,
  input  logic [BYTE_W-1:0] in_src,
  input  logic              in_x,
  input  logic              in_z,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_res,
  output logic              out_c,
  output logic              out_x,
  output logic              out_z,
  output logic              out_n,
  output logic              out_v
);
  bcd_out_t add_o, sub_o, neg_o, pick;
  logic     take;

  bcd_add_path u_add (.d(in_dst), .s(in_src), .x(in_x), .o(add_o));
  bcd_sub_path u_sub (.d(in_dst), .s(in_src), .x(in_x), .o(sub_o));
  bcd_neg_path u_neg (.s(in_src), .x(in_x), .o(neg_o));

  always_comb begin
    if (in_op[1])      pick = neg_o;
    else if (in_op[0]) pick = sub_o;
    else               pick = add_o;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_c     <= 1'b0;
      out_x     <= 1'b0;
      out_z     <= 1'b0;
      out_n     <= 1'b0;
      out_v     <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_res   <= pick.res;
      out_c     <= pick.c;
      out_x     <= pick.c;
      out_z     <= in_z && (pick.res == '0);
      out_n     <= pick.res[BYTE_W-1];
      out_v     <= pick.v;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_ext_copies_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_x == out_c));

  assert_sign_from_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_n == out_res[BYTE_W-1]));

  assert_zero_only_on_zero_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_z) |-> (out_res == '0));

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_c)
                                   && $stable(out_v) && $stable(out_z)));

  assert_empty_accepts_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_neg_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op[1]) |=> !out_v);
endmodule

// File: tb/sim_bcd_byte_alu.sv
module sim_bcd_byte_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  // {op, dst, src, x, z_in, res, c, v, z, n}
  localparam logic [31:0] TBL [NV] = '{
    {2'd0, 8'h45, 8'h38, 1'b0, 1'b1, 8'h83, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd0, 8'h99, 8'h01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'd0, 8'h58, 8'h46, 1'b1, 1'b1, 8'h05, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd0, 8'hFF, 8'hFF, 1'b1, 1'b1, 8'h65, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd1, 8'h45, 8'h38, 1'b0, 1'b1, 8'h07, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd1, 8'h10, 8'h20, 1'b0, 1'b1, 8'h90, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd1, 8'h00, 8'h00, 1'b1, 1'b1, 8'h99, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd1, 8'h80, 8'h01, 1'b0, 1'b1, 8'h79, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd1, 8'hA0, 8'h1F, 1'b1, 1'b1, 8'h7A, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd1, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd2, 8'h55, 8'h01, 1'b0, 1'b1, 8'h99, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd2, 8'h33, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd3, 8'h00, 8'h00, 1'b1, 1'b1, 8'h99, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd2, 8'h00, 8'h25, 1'b0, 1'b1, 8'h75, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_op = 2'd0;
  logic [7:0] in_dst = 8'h00, in_src = 8'h00;
  logic in_x = 1'b0, in_z = 1'b0;
  logic out_valid, out_ready = 1'b1;
  logic [7:0] out_res;
  logic out_c, out_x, out_z, out_n, out_v;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_byte_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src(in_src), .in_x(in_x), .in_z(in_z),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_c(out_c), .out_x(out_x), .out_z(out_z), .out_n(out_n), .out_v(out_v));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 out_valid in reset", {7'b0, out_valid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 out_valid after reset", {7'b0, out_valid}, 8'h00);
    check("R12 in_ready after reset", {7'b0, in_ready}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] e;
      string base;
      e = TBL[i];
      base = e[31] ? ((e[30]) ? "R10" : "R6") : (e[30] ? "R3" : "R1");
      in_op = e[31:30]; in_dst = e[29:22]; in_src = e[21:14];
      in_x = e[13]; in_z = e[12]; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({"R11 out_valid row ", $sformatf("%0d", i)}, {7'b0, out_valid}, 8'h01);
      check({base, " result row ", $sformatf("%0d", i)}, out_res, e[11:4]);
      check({(e[31] ? "R6" : (e[30] ? "R4" : "R1")), " carry row ", $sformatf("%0d", i)},
            {7'b0, out_c}, {7'b0, e[3]});
      check({"R7 extend row ", $sformatf("%0d", i)}, {7'b0, out_x}, {7'b0, e[3]});
      check({(e[31] ? "R6" : (e[30] ? "R5" : "R2")), " overflow row ", $sformatf("%0d", i)},
            {7'b0, out_v}, {7'b0, e[2]});
      check({"R9 zero row ", $sformatf("%0d", i)}, {7'b0, out_z}, {7'b0, e[1]});
      check({"R8 negative row ", $sformatf("%0d", i)}, {7'b0, out_n}, {7'b0, e[0]});
    end

    // R11: valid drops after drain with no new request
    @(negedge clk);
    check("R11 out_valid idle", {7'b0, out_valid}, 8'h00);

    // R11 back-pressure: A = add 12+34 -> 46, B = sub 50-01 -> 49
    out_ready = 1'b0;
    in_op = 2'd0; in_dst = 8'h12; in_src = 8'h34; in_x = 1'b0; in_z = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R11 stalled first result", out_res, 8'h46);
    check("R11 in_ready low while stalled", {7'b0, in_ready}, 8'h00);
    in_op = 2'd1; in_dst = 8'h50; in_src = 8'h01;
    @(negedge clk);
    check("R11 result held under stall", out_res, 8'h46);
    check("R11 valid held under stall", {7'b0, out_valid}, 8'h01);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 result after release", out_res, 8'h49);
    check("R11 valid after release", {7'b0, out_valid}, 8'h01);

    // R9 chained zero: a zero byte with in_z=0 keeps zero clear
    in_op = 2'd2; in_dst = 8'h00; in_src = 8'h00; in_x = 1'b0; in_z = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 zero not set from cleared chain", {7'b0, out_z}, 8'h00);
    check("R6 zero negate result", out_res, 8'h00);

    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule